// File: doc/BRIEF.md
# TCM Wait-State Access Controller

This block sits between a processor's memory port and a synchronous tightly coupled memory array. It turns each processor request into a RAM access that takes either one cycle or two cycles. Reads and writes each have their own timing-mode input, so a system can stretch only the slower direction when the processor clock is too fast for the RAM. The block also drives the RAM clock enable. A force-on input can override the gating so the clock runs in every cycle.

On the processor side, a request is presented with `req_valid` and held until `req_ready` is high. Read data returns with `rsp_valid` in the cycle after the RAM strobe. On the RAM side, the block drives chip enable, write enable, address and write data. For a two-cycle access the first cycle is a setup cycle. In that cycle the block captures the request. The RAM strobe is issued in the second cycle from the captured copy.

Top module: `tcm_wait_ctrl`

## Requirements
- R1: While reset is asserted and just after it with no request, `req_ready`, `rsp_valid` and `ram_ce` are low. `ram_clk_en` is low unless `cfg_force_clk` is 1.
- R2: A mode input value of 0 selects one-cycle timing. With `cfg_rd_mode`=0, an idle read request sees `req_ready`=1 and `ram_ce`=1 in its own cycle, with `ram_addr` equal to `req_addr`.
- R3: With `cfg_wr_mode`=0, an idle write request sees `req_ready`, `ram_ce` and `ram_we` all high in its own cycle, with `ram_addr`/`ram_wdata` equal to the request.
- R4: A mode input value of 1 selects two-cycle timing. In the first cycle `req_ready`=0 and `ram_ce`=0. In the second cycle `req_ready`=1 and `ram_ce`=1, with the same address and write data as in the first cycle.
- R5: The read mode governs only reads and the write mode governs only writes.
- R6: A mode input that changes during the second cycle of a two-cycle access does not alter that access. It still completes in that cycle.
- R7: With `cfg_force_clk`=1, `ram_clk_en` is 1 in every cycle.
- R8: With `cfg_force_clk`=0, `ram_clk_en` is 1 exactly in the cycles that belong to an access (an accepted idle request, or the second cycle of a two-cycle access). It is 0 otherwise.
- R9: `rsp_valid` is 1 for exactly one cycle, in the cycle after a read strobe. `rsp_rdata` then carries the RAM word at the read address. A write never produces `rsp_valid`.
- R10: A new request is accepted in the cycle right after a completion, so one-cycle accesses can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_mode | input | 1 | Read timing: 0 one cycle, 1 two cycles |
| cfg_wr_mode | input | 1 | Write timing: 0 one cycle, 1 two cycles |
| cfg_force_clk | input | 1 | Keep RAM clock enabled in every cycle |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | Request is a write |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request completes this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| ram_clk_en | output | 1 | RAM clock enable |
| ram_ce | output | 1 | RAM chip enable (access strobe) |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, registered in the array |

## Verification
If the phase register held a wrong value, the fault would show within the same cycle. `req_ready` or `ram_ce` would appear in a setup cycle, or would fail to appear in the following one. If the captured address or data were corrupt, the fault would show in the strobe cycle as a `ram_addr`/`ram_wdata` mismatch. A read-back one cycle later would then return a word other than the one written. A wrong response flag shows one cycle after the strobe, as a missing `rsp_valid` or one raised for a write. Clock-gating faults show in the same cycle on `ram_clk_en`, and at the RAM as lost accesses.

// File: rtl/tcm_wait_pkg.sv
package tcm_wait_pkg;
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SECOND = 1'b1
    } tcm_phase_e;

    typedef enum logic {
        MODE_FAST = 1'b0,
        MODE_WAIT = 1'b1
    } tcm_mode_e;
endpackage

// File: rtl/tcm_wait_seq.sv
module tcm_wait_seq
    import tcm_wait_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_mode,
    input  logic          wr_mode,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          start_o,
    output logic          second_o,
    output logic          strobe_o,
    output logic          we_o,
    output logic          ready_o,
    output logic          rsp_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o
);
    typedef struct packed {
        tcm_phase_e    phase;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          we;
        logic          rsp;
    } seq_st_t;

    seq_st_t   st_d, st_q;
    tcm_mode_e sel_mode;
    logic      start_c, strobe_c, ready_c, we_c;

    always_comb begin
        st_d     = st_q;
        start_c  = 1'b0;
        strobe_c = 1'b0;
        ready_c  = 1'b0;
        we_c     = req_we;
        // mode is sampled only when a new access begins
        sel_mode = tcm_mode_e'(req_we ? wr_mode : rd_mode);
        case (st_q.phase)
            PH_IDLE: begin
                start_c = req_valid;
                if (req_valid) begin
                    if (sel_mode == MODE_WAIT) begin
                        st_d.phase = PH_SECOND;
                        st_d.addr  = req_addr;
                        st_d.wdata = req_wdata;
                        st_d.we    = req_we;
                    end else begin
                        strobe_c = 1'b1;
                        ready_c  = 1'b1;
                    end
                end
            end
            PH_SECOND: begin
                strobe_c   = 1'b1;
                ready_c    = 1'b1;
                we_c       = st_q.we;
                st_d.phase = PH_IDLE;
            end
        endcase
        st_d.rsp = strobe_c & ~we_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o  = start_c;
    assign second_o = (st_q.phase == PH_SECOND);
    assign strobe_o = strobe_c;
    assign we_o     = we_c;
    assign ready_o  = ready_c;
    assign rsp_o    = st_q.rsp;
    assign addr_o   = st_q.addr;
    assign wdata_o  = st_q.wdata;
endmodule

// File: rtl/tcm_wait_ramif.sv
module tcm_wait_ramif #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          second,
    input  logic          strobe,
    input  logic          we_eff,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [AW-1:0] hold_addr,
    input  logic [DW-1:0] hold_wdata,
    output logic          ram_ce,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata
);
    always_comb begin
        ram_ce    = strobe;
        ram_we    = strobe & we_eff;
        ram_addr  = second ? hold_addr  : req_addr;
        ram_wdata = second ? hold_wdata : req_wdata;
    end
endmodule

// File: rtl/tcm_wait_clkgate.sv
module tcm_wait_clkgate (
    input  logic force_on,
    input  logic start,
    input  logic second,
    output logic clk_en
);
    assign clk_en = force_on | start | second;
endmodule

// File: rtl/tcm_wait_ctrl.sv
module tcm_wait_ctrl #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_rd_mode,
    input  logic          cfg_wr_mode,
    input  logic          cfg_force_clk,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          ram_clk_en,
    output logic          ram_ce,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);
    logic          start, second, strobe, we_eff;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_wdata;

    tcm_wait_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_mode   (cfg_rd_mode),
        .wr_mode   (cfg_wr_mode),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .start_o   (start),
        .second_o  (second),
        .strobe_o  (strobe),
        .we_o      (we_eff),
        .ready_o   (req_ready),
        .rsp_o     (rsp_valid),
        .addr_o    (hold_addr),
        .wdata_o   (hold_wdata)
    );

    tcm_wait_ramif #(.AW(AW), .DW(DW)) u_ramif (
        .second     (second),
        .strobe     (strobe),
        .we_eff     (we_eff),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata),
        .ram_ce     (ram_ce),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata)
    );

    tcm_wait_clkgate u_clkgate (
        .force_on (cfg_force_clk),
        .start    (start),
        .second   (second),
        .clk_en   (ram_clk_en)
    );

    assign rsp_rdata = ram_rdata;
endmodule

// File: rtl/tcm_wait_ctrl_chk.sv
module tcm_wait_ctrl_chk #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_force_clk,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          ram_clk_en,
    input logic          ram_ce,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic [DW-1:0] ram_wdata
);
    assert_ready_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> ram_ce);

    assert_wait_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_ready && ram_ce);

    assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> $stable(ram_addr));

    assert_force_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_force_clk |-> ram_clk_en);

    assert_strobe_clocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce |-> ram_clk_en);

    assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(ram_ce && !ram_we));

    assert_no_rsp_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce && ram_we |=> !rsp_valid);
endmodule

bind tcm_wait_ctrl tcm_wait_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_force_clk (cfg_force_clk),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .ram_clk_en    (ram_clk_en),
    .ram_ce        (ram_ce),
    .ram_we        (ram_we),
    .ram_addr      (ram_addr),
    .ram_wdata     (ram_wdata)
);

// File: tb/tcm_wait_ctrl_test.sv
module tcm_wait_ctrl_test;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_rd_mode = 1'b0, cfg_wr_mode = 1'b0, cfg_force_clk = 1'b0;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, ram_clk_en, ram_ce, ram_we;
    logic [DW-1:0] rsp_rdata, ram_wdata;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_rdata = '0;

    logic [DW-1:0] arr [NW];
    logic [DW-1:0] ref_mem [NW];
    int n_vec = 0, n_bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    tcm_wait_ctrl #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_rd_mode(cfg_rd_mode), .cfg_wr_mode(cfg_wr_mode),
        .cfg_force_clk(cfg_force_clk), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_clk_en(ram_clk_en),
        .ram_ce(ram_ce), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    // behavioural synchronous RAM: acts only when clocked and enabled
    always @(posedge clk) begin
        if (ram_clk_en && ram_ce) begin
            if (ram_we) arr[ram_addr] <= ram_wdata;
            else        ram_rdata <= arr[ram_addr];
        end
    end

    function automatic logic [DW-1:0] init_word(int i);
        return DW'(i * 32'h0101_0003 + 32'h55);
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one access followed by one idle cycle that checks the response
    task automatic access(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic flip);
        logic slow;
        logic sr, sw;
        slow = we ? cfg_wr_mode : cfg_rd_mode;
        sr = cfg_rd_mode; sw = cfg_wr_mode;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        #1;
        chk("R8 clk_en in access", DW'(ram_clk_en), 1);
        if (!slow) begin
            chk(we ? "R3 ready fast" : "R2 ready fast", DW'(req_ready), 1);
            chk(we ? "R3 ce fast" : "R2 ce fast", DW'(ram_ce), 1);
            chk("R3 we matches", DW'(ram_we), DW'(we));
            chk("R2 addr", DW'(ram_addr), DW'(a));
            if (we) chk("R3 wdata", ram_wdata, d);
        end else begin
            chk("R4 ready low first", DW'(req_ready), 0);
            chk("R4 ce low first", DW'(ram_ce), 0);
            @(negedge clk);
            if (flip) begin
                cfg_rd_mode = ~cfg_rd_mode; cfg_wr_mode = ~cfg_wr_mode;
            end
            #1;
            chk(flip ? "R6 ready second after flip" : "R4 ready second", DW'(req_ready), 1);
            chk("R4 ce second", DW'(ram_ce), 1);
            chk("R5 we second", DW'(ram_we), DW'(we));
            chk("R4 addr held", DW'(ram_addr), DW'(a));
            chk("R8 clk_en second", DW'(ram_clk_en), 1);
            if (we) chk("R4 wdata held", ram_wdata, d);
        end
        if (we) ref_mem[a] = d;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = ~d;
        cfg_rd_mode = sr; cfg_wr_mode = sw;
        #1;
        chk("R9 rsp_valid", DW'(rsp_valid), DW'(!we));
        if (!we) chk("R9 rsp data", rsp_rdata, ref_mem[a]);
        chk("R8 idle ready", DW'(req_ready), 0);
        chk(cfg_force_clk ? "R7 idle clk_en" : "R8 idle clk_en", DW'(ram_clk_en), DW'(cfg_force_clk));
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            arr[i] = init_word(i);
            ref_mem[i] = init_word(i);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ready in reset", DW'(req_ready), 0);
        chk("R1 rsp in reset", DW'(rsp_valid), 0);
        chk("R1 clk_en in reset", DW'(ram_clk_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 ce after reset", DW'(ram_ce), 0);
        chk("R1 ready after reset", DW'(req_ready), 0);
        chk("R1 clk_en after reset", DW'(ram_clk_en), 0);

        // directed: fast read/write, slow read/write, mixed modes
        access(1'b0, 6'd3, '0, 1'b0);
        access(1'b1, 6'd3, 32'hCAFE_0001, 1'b0);
        access(1'b0, 6'd3, '0, 1'b0);
        cfg_rd_mode = 1'b1;
        access(1'b1, 6'd7, 32'h1234_5678, 1'b0);   // R5 write still fast
        access(1'b0, 6'd7, '0, 1'b0);              // R5 read slow
        cfg_rd_mode = 1'b0; cfg_wr_mode = 1'b1;
        access(1'b0, 6'd8, '0, 1'b0);              // R5 read fast
        access(1'b1, 6'd8, 32'hDEAD_BEEF, 1'b1);   // R6 flip in second cycle
        cfg_rd_mode = 1'b1;
        access(1'b0, 6'd8, '0, 1'b1);              // R6 flip on read
        cfg_rd_mode = 1'b0; cfg_wr_mode = 1'b0;

        // R7: forced clock in idle
        cfg_force_clk = 1'b1;
        @(negedge clk); #1;
        chk("R7 forced idle clk_en", DW'(ram_clk_en), 1);
        cfg_force_clk = 1'b0;
        #1;
        chk("R8 ungated idle clk_en", DW'(ram_clk_en), 0);

        // R10: back-to-back fast reads
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 6'd3; #1;
        chk("R10 first accepted", DW'(req_ready), 1);
        @(negedge clk);
        req_addr = 6'd8; #1;
        chk("R10 second accepted", DW'(req_ready), 1);
        chk("R10 first rsp", DW'(rsp_valid), 1);
        chk("R10 first data", rsp_rdata, ref_mem[3]);
        @(negedge clk);
        req_valid = 1'b0; #1;
        chk("R10 second data", rsp_rdata, ref_mem[8]);
        chk("R9 rsp valid second", DW'(rsp_valid), 1);
        @(negedge clk); #1;
        chk("R9 rsp single cycle", DW'(rsp_valid), 0);

        // constrained random
        for (int k = 0; k < 400; k++) begin
            cfg_rd_mode   = 1'($urandom);
            cfg_wr_mode   = 1'($urandom);
            cfg_force_clk = ($urandom % 4) == 0;
            access(1'($urandom), AW'($urandom), $urandom, 1'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule